// File: doc/BRIEF.md
# Multiplexed-Bus Target Responder

This block is the target side of a parallel bus on which the address and the data share one set of lines and each transfer opens with an address phase. The block watches the frame strobe. It latches the address and command on the clock where the frame strobe falls, decodes them one clock later and, when they fall into one of its two windows (memory or I/O), claims the access with its device-select strobe. It then moves data to or from a small internal register array, one word per completed data phase. A data phase completes on a clock where both ready strobes are low.

A target may refuse an access. When the `busy_i` input is high at decode time, the block signals a retry: it raises stop and moves no data. When a burst would run past the last register of the array, the block disconnects after transferring the last word. Either termination keeps stop low until the initiator drops the frame strobe. Every claimed access ends with one turnaround clock, during which the control strobes are driven high before they are released. A new address phase that arrives during that clock is decoded at once.

A two-state lock tracker samples the lock line each time a transaction starts. Each shared bus line is split into an input, an output and an enable.

Top module: `bus_target_resp`

## Requirements
- R1: While reset is high and on the first clock after it, `devsel_n_o`, `trdy_n_o` and `stop_n_o` are 1, `ctl_oe_o` and `ad_oe_o` are 0 and `locked_o` is 0.
- R2: The block claims an access only for commands 2 (I/O read), 3 (I/O write), 6 (memory read) and 7 (memory write). The address must lie in 0x40–0x47 for memory commands and in 0xA0–0xA7 for I/O commands. An access that is not claimed keeps `devsel_n_o` high through the whole transaction, and the block does not restart while the frame strobe stays low.
- R3: A clock counts as the address phase when `frame_n_i` is low on it and was high on the clock before. `devsel_n_o` first goes low in the second clock after the address phase and never earlier. `trdy_n_o` is never low while `devsel_n_o` is high.
- R4: On a read, `ad_oe_o` is 0 during the clock that follows the address phase. In each data phase with `trdy_n_o` low, `ad_oe_o` is 1 and `ad_o` holds the array word at the current index.
- R5: On a write, a data phase that completes stores `ad_i` into the array word at the current index when `cbe_n_i[0]` is 0. When `cbe_n_i[0]` is 1, the word is left unchanged.
- R6: The index starts at the low three address bits and advances by one after each completed data phase. A clock with `irdy_n_i` high transfers nothing and leaves the index unchanged.
- R7: When `busy_i` is high on the decode clock of a claimed access, the block asserts `devsel_n_o` and `stop_n_o` with `trdy_n_o` high (retry), and no data is transferred.
- R8: When a data phase completes at index 7 while `frame_n_i` is still low, the next clock shows `stop_n_o` low and `trdy_n_o` high (disconnect after data).
- R9: Once `stop_n_o` is low, it stays low until the block samples `frame_n_i` high.
- R10: After the last data phase or a termination, there is exactly one clock with `ctl_oe_o` at 1 and all three control strobes at 1. After that clock, `ctl_oe_o` drops to 0.
- R11: An address phase that falls in the turnaround clock is decoded without an idle clock in between.
- R12: `locked_o` takes the inverse of `lock_n_i` at each transaction start. It also falls to 0 on any clock where `lock_n_i` and `frame_n_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n_i | input | 1 | Frame strobe from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| lock_n_i | input | 1 | Lock line, active low |
| busy_i | input | 1 | Forces a retry of the access being decoded |
| ad_i | input | DW | Address/data lines as seen on the bus |
| cbe_n_i | input | 4 | Command in the address phase; byte enable (bit 0) in data phases |
| ad_o | output | DW | Read data driven onto the address/data lines |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| devsel_n_o | output | 1 | Device select, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Stop request, active low |
| ctl_oe_o | output | 1 | Output enable for the three control strobes |
| locked_o | output | 1 | Lock tracker state (1 = locked) |

## Verification
Directed transactions cover several cases. Writes followed by reads show that data reaches the right word and that masked writes are skipped. A burst that starts near the top of the array separates normal completion from disconnect. Busy accesses separate retry from a real transfer. Wrong commands and out-of-window addresses check that the decode does not claim them. A back-to-back pair confirms that decode works straight out of turnaround. Random transactions then mix windows, burst lengths, initiator wait states, byte masking, lock use and delayed frame release, against a reference memory in the bench. A wrong index, a missed wait state or a stray write therefore shows up as a read mismatch.

// File: rtl/btr_pkg.sv
package btr_pkg;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_IO_RD  = 4'h2;
    localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'h3;
    localparam logic [CMD_W-1:0] CMD_MEM_RD = 4'h6;
    localparam logic [CMD_W-1:0] CMD_MEM_WR = 4'h7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SNOOP,
        ST_XFER,
        ST_BACKOFF,
        ST_TURN
    } tgt_state_e;

    typedef enum logic [1:0] {
        SPC_NONE,
        SPC_IO,
        SPC_MEM
    } space_e;

    typedef struct packed {
        logic hit;
        logic rd;
    } decode_t;

    function automatic space_e cmd_space(input logic [CMD_W-1:0] c);
        case (c)
            CMD_IO_RD, CMD_IO_WR:   return SPC_IO;
            CMD_MEM_RD, CMD_MEM_WR: return SPC_MEM;
            default:                return SPC_NONE;
        endcase
    endfunction

    function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
        return !c[0];
    endfunction

endpackage

// File: rtl/btr_decode.sv
module btr_decode
    import btr_pkg::*;
#(
    parameter int             DW       = 8,
    parameter int             IW       = 3,
    parameter logic [DW-1:0]  MEM_BASE = DW'('h40),
    parameter logic [DW-1:0]  IO_BASE  = DW'('hA0)
) (
    input  logic [DW-1:0]    addr,
    input  logic [CMD_W-1:0] cmd,
    output decode_t          dec
);
    logic mem_match, io_match;

    assign mem_match = (addr[DW-1:IW] == MEM_BASE[DW-1:IW]);
    assign io_match  = (addr[DW-1:IW] == IO_BASE[DW-1:IW]);

    always_comb begin
        dec.rd = cmd_is_read(cmd);
        case (cmd_space(cmd))
            SPC_MEM: dec.hit = mem_match;
            SPC_IO:  dec.hit = io_match;
            default: dec.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/btr_regfile.sv
module btr_regfile #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g] <= '0;
            end else if (we && (idx == IW'(g))) begin
                word_q[g] <= wdata;
            end
        end
    end

    assign rdata = word_q[idx];
endmodule

// File: rtl/btr_lock.sv
module btr_lock (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic lock_n,
    input  logic frame_n,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (start) begin
            locked <= !lock_n;
        end else if (lock_n && frame_n) begin
            locked <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_target_resp.sv
module bus_target_resp
    import btr_pkg::*;
#(
    parameter int            DW       = 8,
    parameter int            DEPTH    = 8,
    parameter logic [DW-1:0] MEM_BASE = DW'('h40),
    parameter logic [DW-1:0] IO_BASE  = DW'('hA0)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic             lock_n_i,
    input  logic             busy_i,
    input  logic [DW-1:0]    ad_i,
    input  logic [CMD_W-1:0] cbe_n_i,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe_o,
    output logic             devsel_n_o,
    output logic             trdy_n_o,
    output logic             stop_n_o,
    output logic             ctl_oe_o,
    output logic             locked_o
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    tgt_state_e       st_q, st_d;
    logic             frame_q;
    logic [DW-1:0]    addr_q;
    logic [CMD_W-1:0] cmd_q;
    logic [IW-1:0]    idx_q;
    decode_t          dec;
    logic             start, beat, we;

    assign start = ((st_q == ST_IDLE) || (st_q == ST_TURN)) && !frame_n_i && frame_q;
    assign beat  = (st_q == ST_XFER) && !irdy_n_i;
    assign we    = beat && !dec.rd && !cbe_n_i[0];

    btr_decode #(.DW(DW), .IW(IW), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u_dec (
        .addr (addr_q),
        .cmd  (cmd_q),
        .dec  (dec)
    );

    btr_regfile #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .idx   (idx_q),
        .wdata (ad_i),
        .rdata (ad_o)
    );

    btr_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .lock_n  (lock_n_i),
        .frame_n (frame_n_i),
        .locked  (locked_o)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = ST_SNOOP;
            ST_SNOOP: begin
                if (!dec.hit)    st_d = ST_IDLE;
                else if (busy_i) st_d = ST_BACKOFF;
                else             st_d = ST_XFER;
            end
            ST_XFER: begin
                if (beat) begin
                    if (frame_n_i)             st_d = ST_TURN;
                    else if (idx_q == LAST_IDX) st_d = ST_BACKOFF;
                end
            end
            ST_BACKOFF: if (frame_n_i) st_d = ST_TURN;
            ST_TURN:    st_d = start ? ST_SNOOP : ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            frame_q <= 1'b1;
            addr_q  <= '0;
            cmd_q   <= '0;
            idx_q   <= '0;
        end else begin
            st_q    <= st_d;
            frame_q <= frame_n_i;
            if (start) begin
                addr_q <= ad_i;
                cmd_q  <= cbe_n_i;
                idx_q  <= ad_i[IW-1:0];
            end else if (beat) begin
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    assign devsel_n_o = !((st_q == ST_XFER) || (st_q == ST_BACKOFF));
    assign trdy_n_o   = (st_q != ST_XFER);
    assign stop_n_o   = (st_q != ST_BACKOFF);
    assign ctl_oe_o   = (st_q == ST_XFER) || (st_q == ST_BACKOFF) || (st_q == ST_TURN);
    assign ad_oe_o    = (st_q == ST_XFER) && dec.rd;
endmodule

// File: rtl/btr_checker.sv
module btr_checker (
    input logic clk,
    input logic rst,
    input logic frame_n_i,
    input logic lock_n_i,
    input logic devsel_n_o,
    input logic trdy_n_o,
    input logic stop_n_o,
    input logic ctl_oe_o,
    input logic ad_oe_o,
    input logic locked_o
);
    AST_TRDY_AFTER_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        !trdy_n_o |-> !devsel_n_o); // R3

    AST_DEVSEL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n_o) |-> !$past(frame_n_i, 2)); // R3

    AST_READ_DRIVE_CLAIMED: assert property (@(posedge clk) disable iff (rst)
        ad_oe_o |-> (!devsel_n_o && !trdy_n_o)); // R4

    AST_STOP_EXCL_TRDY: assert property (@(posedge clk) disable iff (rst)
        !stop_n_o |-> trdy_n_o); // R7

    AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!stop_n_o && !frame_n_i) |=> !stop_n_o); // R9

    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_oe_o) |-> $past(devsel_n_o && trdy_n_o && stop_n_o)); // R10

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> !$past(lock_n_i)); // R12
endmodule

bind bus_target_resp btr_checker u_chk (.*);

// File: tb/tb_bus_target_resp.sv
module tb_bus_target_resp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_n = 1'b1, irdy_n = 1'b1, lock_n = 1'b1, busy = 1'b0;
    logic [7:0] ad_i = '0;
    logic [3:0] cbe_n = '0;
    logic [7:0] ad_o;
    logic       ad_oe, devsel_n, trdy_n, stop_n, ctl_oe, locked;

    int  nchk = 0, nfail = 0;
    bit  tar_pend = 0;
    bit  lkm = 0;
    bit  finished = 0;
    logic [7:0] mdl [8];

    always #10 clk = ~clk;

    bus_target_resp dut (
        .clk(clk), .rst(rst), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
        .lock_n_i(lock_n), .busy_i(busy), .ad_i(ad_i), .cbe_n_i(cbe_n),
        .ad_o(ad_o), .ad_oe_o(ad_oe), .devsel_n_o(devsel_n), .trdy_n_o(trdy_n),
        .stop_n_o(stop_n), .ctl_oe_o(ctl_oe), .locked_o(locked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [7:0] a, input logic [3:0] c);
        if (c == 4'h2 || c == 4'h3) return a[7:3] == 5'b10100;
        if (c == 4'h6 || c == 4'h7) return a[7:3] == 5'b01000;
        return 1'b0;
    endfunction

    task automatic chk_tar(input string tag);
        chk(tag, {ctl_oe, devsel_n, trdy_n, stop_n, ad_oe}, 5'b11110);
    endtask

    task automatic idle_cycle(input bit rel);
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; busy = 1'b0;
        if (rel) lock_n = 1'b1;
        if (tar_pend) chk_tar("R10 turnaround");
        else chk("R10 released", {ctl_oe, devsel_n, trdy_n, stop_n, ad_oe}, 5'b01110);
        tar_pend = 0;
        chk("R12 lock state", locked, lkm);
        if (lock_n) lkm = 0;
    endtask

    task automatic txn(input logic [7:0] a, input logic [3:0] c, input int n,
                       input bit bz, input bit lk_on, input int hold);
        bit hit, rd, done, stopseen, first, comp, be_off, exp_disc;
        int k, idx, hc;
        logic [7:0] wd;
        hit = exp_hit(a, c); rd = !c[0]; idx = int'(a[2:0]);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_i = a; cbe_n = c; busy = bz; lock_n = !lk_on;
        if (tar_pend) chk_tar("R11 start in turnaround");
        tar_pend = 0;
        chk("R12 lock before start", locked, lkm);
        lkm = lk_on;
        @(negedge clk);
        irdy_n = 1'b0; cbe_n = 4'h0; ad_i = 8'($urandom);
        chk("R3 no devsel in first clock", devsel_n, 1'b1);
        chk("R4 turnaround clock undriven", ad_oe, 1'b0);
        chk("R12 lock sampled at start", locked, lkm);
        if (!hit) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk("R2 unclaimed", {devsel_n, ctl_oe}, 2'b10);
            end
            @(negedge clk);
            frame_n = 1'b1;
            chk("R2 unclaimed end", {devsel_n, ctl_oe}, 2'b10);
        end else begin
            k = 0; done = 0; stopseen = 0; hc = 0; first = 1; exp_disc = 0;
            while (!done) begin
                @(negedge clk);
                if (stopseen) begin
                    if (hc >= hold) frame_n = 1'b1; else hc++;
                    irdy_n = 1'b0;
                end else begin
                    irdy_n = ($urandom_range(0, 3) == 0);
                    if (!irdy_n && k == n - 1) frame_n = 1'b1;
                end
                be_off = ($urandom_range(0, 7) == 0);
                cbe_n = {3'b000, be_off};
                wd = 8'($urandom);
                ad_i = wd;
                if (first) begin
                    chk("R3 devsel in second clock", devsel_n, 1'b0);
                    chk("R7 retry strobes", {trdy_n, stop_n}, {bz, !bz});
                    first = 0;
                end
                if (exp_disc) chk("R8 disconnect", {stop_n, trdy_n}, 2'b01);
                exp_disc = 0;
                if (stopseen) chk("R9 stop held", stop_n, 1'b0);
                comp = !irdy_n && !trdy_n;
                if (!stop_n) begin
                    chk("R7 no data with stop", trdy_n, 1'b1);
                    stopseen = 1;
                    if (frame_n) done = 1;
                end else if (comp) begin
                    if (rd) chk("R4 read data", {ad_oe, ad_o}, {1'b1, mdl[idx]});
                    else if (!be_off) mdl[idx] = wd;
                    k++;
                    if (frame_n) done = 1;
                    else if (idx == 7) exp_disc = 1;
                    idx = (idx + 1) % 8;
                end
            end
            tar_pend = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {devsel_n, trdy_n, stop_n, ctl_oe, ad_oe, locked}, 6'b111000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {devsel_n, trdy_n, stop_n, ctl_oe, ad_oe, locked}, 6'b111000);

        txn(8'h40, 4'h7, 4, 0, 0, 0); idle_cycle(0); idle_cycle(0);   // R5 R6 write burst
        txn(8'h40, 4'h6, 4, 0, 0, 0); idle_cycle(0);                  // R4 read back
        txn(8'hA6, 4'h3, 4, 0, 0, 0); idle_cycle(0);                  // R8 disconnect
        txn(8'hA7, 4'h2, 1, 0, 0, 0); idle_cycle(0);
        txn(8'h43, 4'h7, 2, 1, 0, 2); idle_cycle(0);                  // R7 R9 retry, held frame
        txn(8'h43, 4'h6, 1, 0, 0, 0); idle_cycle(0);
        txn(8'h50, 4'h6, 2, 0, 0, 0); idle_cycle(0);                  // R2 window miss
        txn(8'h40, 4'hA, 2, 0, 0, 0); idle_cycle(0);                  // R2 command miss
        txn(8'hA1, 4'h3, 2, 0, 0, 0);                                 // R11 back-to-back
        txn(8'hA1, 4'h2, 2, 0, 0, 0); idle_cycle(0);
        txn(8'h44, 4'h6, 1, 0, 1, 0); idle_cycle(0); idle_cycle(0);   // R12 locked
        idle_cycle(1); idle_cycle(0);                                 // R12 release

        for (int t = 0; t < 300; t++) begin
            logic [7:0] a;
            logic [3:0] c;
            int r;
            r = $urandom_range(0, 9);
            if (r < 4)      a = {5'b01000, 3'($urandom)};
            else if (r < 8) a = {5'b10100, 3'($urandom)};
            else            a = 8'($urandom);
            r = $urandom_range(0, 9);
            if (r < 8) c = {1'b0, r[0] ? 1'b1 : 1'b0, 1'b1, r[1]};
            else       c = 4'($urandom);
            txn(a, c, $urandom_range(1, 6), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 4) == 0), $urandom_range(0, 2));
            if ($urandom_range(0, 2) != 0) idle_cycle($urandom_range(0, 3) == 0);
        end
        idle_cycle(1); idle_cycle(1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule